// File: doc/BRIEF.md
# Posted-Write AHB to APB Bridge

This block connects a single-beat AHB-Lite subordinate port to an APB requester port. The APB side runs on a clock enable derived from the AHB clock by a divider whose ratio is an input. Every APB control, address and data change happens only on an enabled cycle. Peripherals on the APB side use the same enable, which is also an output.

A write is posted. Its address and data go into a one-entry buffer, and the AHB transfer ends with no wait state. The APB setup and access phases run later, at the APB pace. Until they finish, the peripheral register keeps its old value. A level flag that the write is meant to clear therefore stays high for several AHB cycles after the AHB side has finished.

A read that follows a posted write is held with HREADYOUT low until the buffered write has fully completed on APB. Only then does the read's own APB transfer start. Write-then-read ordering therefore holds at any clock ratio. A second write that meets a full buffer waits the same way. Read data and PSLVERR return on HRDATA and HRESP. A write error has no effect on the AHB side.

Top module: `posted_apb_bridge`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, HREADYOUT is 1, HRESP is 0, PSEL is 0 and PENABLE is 0.
- R2: A write data phase that finds the buffer empty completes with HREADYOUT at 1 in that same cycle (zero wait states).
- R3: The APB enable pulses once every N AHB cycles, where N is the ratio input. A ratio of 0 acts as 1, and a ratio above 16 acts as 16. PSEL, PENABLE, PWRITE, PADDR and PWDATA change only in the cycle after a pulse. The setup phase therefore lasts exactly N cycles.
- R4: Each APB transfer has a setup phase (PSEL 1, PENABLE 0) followed by an access phase (PSEL 1, PENABLE 1). The access phase lasts until PREADY is seen high on an enabled cycle, so it lasts (waits+1)·N cycles. A write drives the captured address and data, with PWRITE at 1.
- R5: A read that arrives while a posted write is outstanding is stalled with HREADYOUT at 0. No APB read starts while the buffer holds a write. As a result, a write followed at once by a read of the same register returns the written effect: a write-one-to-clear of a set flag reads back 0, and the flag is already low when the read completes. Right after the write's AHB completion, the flag is still high.
- R6: A read completes with HREADYOUT at 1 for one cycle, and HRDATA then equals the PRDATA that was sampled when PREADY was accepted.
- R7: A read that ends with PSLVERR at 1 gives a two-cycle AHB error. In the first cycle HRESP is 1 and HREADYOUT is 0. In the second cycle HRESP is 1 and HREADYOUT is 1.
- R8: A write data phase that meets a full buffer holds HREADYOUT at 0 until the buffered write has completed on APB. The buffered entry is kept until its APB access completes.
- R9: Transfers with HTRANS IDLE (2'b00) or BUSY (2'b01) are ignored: they start no APB transfer, they do not alter any register, and HREADYOUT stays 1. Only NONSEQ (2'b10) and SEQ (2'b11) are accepted.
- R10: PSLVERR returned on a write is dropped. The write still ends on AHB with zero wait states, and HRESP stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | AHB clock; the APB side runs on the same clock, qualified by the enable |
| rst_n | input | 1 | Synchronous active-low reset |
| div_ratio | input | DIV_W (5) | AHB cycles per APB enable pulse, 1 to MAX_DIV |
| hsel | input | 1 | Subordinate select |
| haddr | input | ADDR_W | Transfer address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 for write, 0 for read |
| hwdata | input | DATA_W | Write data, valid in the data phase |
| hready | input | 1 | Bus-wide ready; the previous transfer is complete |
| hreadyout | output | 1 | Ready from this subordinate |
| hresp | output | 1 | Error response |
| hrdata | output | DATA_W | Read data |
| pclk_en | output | 1 | APB clock-enable pulse |
| psel | output | 1 | APB select |
| penable | output | 1 | APB access-phase marker |
| pwrite | output | 1 | APB direction |
| paddr | output | ADDR_W | APB address |
| pwdata | output | DATA_W | APB write data |
| prdata | input | DATA_W | APB read data |
| pready | input | 1 | APB ready, sampled on enabled cycles |
| pslverr | input | 1 | APB error, sampled with PREADY |

## Verification
The hardest case to reach is a read whose address phase overlaps the data phase of a write to the same register. The write must still be in the buffer when the read arrives, and the register must be one whose visible state changes only when the write lands. The bench models a peripheral with a write-one-to-clear flag and programmable wait states. It issues the write and the read in consecutive address phases, with the read's address presented while the write's data phase completes. A table sweeps ratios from 1 to 16 and several wait-state counts. For each entry the bench checks that the flag is still set just after the write's AHB completion, that it is clear by the time the read returns, and that the value read back is the updated one.

// File: rtl/pab_pkg.sv
// Shared types for the posted-write AHB to APB bridge.
// Assumes single-beat transfers only; HTRANS encodings are the standard ones.
package pab_pkg;

    // AHB transfer type codes
    localparam logic [1:0] HT_IDLE   = 2'b00;
    localparam logic [1:0] HT_BUSY   = 2'b01;
    localparam logic [1:0] HT_NONSEQ = 2'b10;
    localparam logic [1:0] HT_SEQ    = 2'b11;

    // APB sequencer phases
    typedef enum logic [1:0] {
        AP_IDLE,
        AP_SETUP,
        AP_ACCESS
    } apb_st_t;

    // AHB data-phase states
    typedef enum logic [2:0] {
        AH_IDLE,
        AH_WDATA,
        AH_RWAIT,
        AH_ROK,
        AH_ERR1,
        AH_ERR2
    } ahb_st_t;

endpackage

// File: rtl/pab_clk_en.sv
// APB clock-enable generator.
// Emits a one-cycle pulse every N clk cycles, N taken from div_ratio.
// A ratio of 0 behaves as 1 and a ratio above MAX_DIV behaves as MAX_DIV.
// If the ratio is lowered mid-count, the next cycle pulses at once.
module pab_clk_en #(
    parameter int MAX_DIV = 16,
    parameter int DIV_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_ratio,
    output logic             pen
);
    localparam int CNT_W = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;

    logic [CNT_W-1:0] lim;
    logic [CNT_W-1:0] cnt;

    // Clamp the requested ratio into the supported range, minus one
    always_comb begin
        if (div_ratio == '0) begin
            lim = '0;
        end else if (div_ratio > DIV_W'(MAX_DIV)) begin
            lim = CNT_W'(MAX_DIV - 1);
        end else begin
            lim = CNT_W'(div_ratio - 1'b1);
        end
    end

    assign pen = (cnt >= lim);

    // Free-running divider counter, restarts after each pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (pen) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pab_wbuf.sv
// Single-entry posted-write buffer.
// Assumes push is only raised while the entry is empty; pop marks the
// entry empty once its APB access has completed.
module pab_wbuf #(
    parameter int AW = 12,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic          valid,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] data
);

    // Occupancy flag: set on push, cleared on pop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
        end else if (push) begin
            valid <= 1'b1;
        end else if (pop) begin
            valid <= 1'b0;
        end
    end

    // Entry payload capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            data <= '0;
        end else if (push) begin
            addr <= push_addr;
            data <= push_data;
        end
    end

endmodule

// File: rtl/pab_apb_seq.sv
// APB requester sequencer.
// Runs setup and access phases on the APB clock enable only. A buffered
// write always wins over a read request, so a read can never overtake a
// posted write. All APB outputs are registered and change only when pen is high.
module pab_apb_seq
    import pab_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pen,
    input  logic          wr_valid,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          wr_done,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_done,
    output logic [DW-1:0] rd_data,
    output logic          rd_err,
    output logic          psel,
    output logic          penable,
    output logic          pwrite,
    output logic [AW-1:0] paddr,
    output logic [DW-1:0] pwdata,
    input  logic [DW-1:0] prdata,
    input  logic          pready,
    input  logic          pslverr
);
    apb_st_t st;
    logic    xfer_done;

    assign xfer_done = pen && (st == AP_ACCESS) && pready;
    assign wr_done   = xfer_done && pwrite;
    assign rd_done   = xfer_done && !pwrite;
    assign rd_data   = prdata;
    assign rd_err    = pslverr;

    // Phase sequencing and APB output registers, advanced on enabled cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= AP_IDLE;
            psel    <= 1'b0;
            penable <= 1'b0;
            pwrite  <= 1'b0;
            paddr   <= '0;
            pwdata  <= '0;
        end else if (pen) begin
            case (st)
                AP_IDLE: begin
                    if (wr_valid) begin
                        psel   <= 1'b1;
                        pwrite <= 1'b1;
                        paddr  <= wr_addr;
                        pwdata <= wr_data;
                        st     <= AP_SETUP;
                    end else if (rd_req) begin
                        psel   <= 1'b1;
                        pwrite <= 1'b0;
                        paddr  <= rd_addr;
                        st     <= AP_SETUP;
                    end
                end
                AP_SETUP: begin
                    penable <= 1'b1;
                    st      <= AP_ACCESS;
                end
                AP_ACCESS: begin
                    if (pready) begin
                        psel    <= 1'b0;
                        penable <= 1'b0;
                        st      <= AP_IDLE;
                    end
                end
                default: begin
                    psel    <= 1'b0;
                    penable <= 1'b0;
                    st      <= AP_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/posted_apb_bridge.sv
// AHB-Lite subordinate to APB requester bridge with one posted write.
// Writes finish on AHB once captured; reads wait until any buffered write
// has completed on APB, then return PRDATA or a two-cycle error.
// Assumes single-beat transfers and a system where hready reflects the
// completion of the previous data phase.
module posted_apb_bridge
    import pab_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int MAX_DIV = 16,
    localparam int DIV_W  = $clog2(MAX_DIV + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_ratio,
    input  logic              hsel,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [DATA_W-1:0] hwdata,
    input  logic              hready,
    output logic              hreadyout,
    output logic              hresp,
    output logic [DATA_W-1:0] hrdata,
    output logic              pclk_en,
    output logic              psel,
    output logic              penable,
    output logic              pwrite,
    output logic [ADDR_W-1:0] paddr,
    output logic [DATA_W-1:0] pwdata,
    input  logic [DATA_W-1:0] prdata,
    input  logic              pready,
    input  logic              pslverr
);
    ahb_st_t             ah_st;
    logic [ADDR_W-1:0]   dp_addr;
    logic [DATA_W-1:0]   rd_q;
    logic                pen;
    logic                buf_valid;
    logic [ADDR_W-1:0]   buf_addr;
    logic [DATA_W-1:0]   buf_data;
    logic                push;
    logic                wr_done;
    logic                rd_req;
    logic                rd_done;
    logic [DATA_W-1:0]   rd_data;
    logic                rd_err;
    logic                addr_ok;

    pab_clk_en #(
        .MAX_DIV (MAX_DIV),
        .DIV_W   (DIV_W)
    ) u_clk_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_ratio (div_ratio),
        .pen       (pen)
    );

    pab_wbuf #(
        .AW (ADDR_W),
        .DW (DATA_W)
    ) u_wbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_addr (dp_addr),
        .push_data (hwdata),
        .pop       (wr_done),
        .valid     (buf_valid),
        .addr      (buf_addr),
        .data      (buf_data)
    );

    pab_apb_seq #(
        .AW (ADDR_W),
        .DW (DATA_W)
    ) u_apb_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pen      (pen),
        .wr_valid (buf_valid),
        .wr_addr  (buf_addr),
        .wr_data  (buf_data),
        .wr_done  (wr_done),
        .rd_req   (rd_req),
        .rd_addr  (dp_addr),
        .rd_done  (rd_done),
        .rd_data  (rd_data),
        .rd_err   (rd_err),
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .paddr    (paddr),
        .pwdata   (pwdata),
        .prdata   (prdata),
        .pready   (pready),
        .pslverr  (pslverr)
    );

    assign pclk_en = pen;
    assign addr_ok = hsel && hready && ((htrans == HT_NONSEQ) || (htrans == HT_SEQ));
    assign push    = (ah_st == AH_WDATA) && !buf_valid;
    assign rd_req  = (ah_st == AH_RWAIT);
    assign hrdata  = rd_q;
    assign hresp   = (ah_st == AH_ERR1) || (ah_st == AH_ERR2);

    // Ready for the current data phase, decided by its state
    always_comb begin
        case (ah_st)
            AH_IDLE:  hreadyout = 1'b1;
            AH_WDATA: hreadyout = !buf_valid;
            AH_RWAIT: hreadyout = 1'b0;
            AH_ROK:   hreadyout = 1'b1;
            AH_ERR1:  hreadyout = 1'b0;
            AH_ERR2:  hreadyout = 1'b1;
            default:  hreadyout = 1'b1;
        endcase
    end

    // AHB data-phase tracking: accept address phases and await APB results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ah_st   <= AH_IDLE;
            dp_addr <= '0;
            rd_q    <= '0;
        end else if (hreadyout) begin
            if (addr_ok) begin
                dp_addr <= haddr;
                ah_st   <= hwrite ? AH_WDATA : AH_RWAIT;
            end else begin
                ah_st   <= AH_IDLE;
            end
        end else if ((ah_st == AH_RWAIT) && rd_done) begin
            rd_q  <= rd_data;
            ah_st <= rd_err ? AH_ERR1 : AH_ROK;
        end else if (ah_st == AH_ERR1) begin
            ah_st <= AH_ERR2;
        end
    end

endmodule

// File: rtl/pab_checker.sv
// Protocol checker for posted_apb_bridge, attached with bind below.
// Observes the APB pins, the enable pulse, the buffer occupancy and the
// AHB response pins.
module pab_checker #(
    parameter int AW = 12,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pen,
    input logic          buf_valid,
    input logic          hreadyout,
    input logic          hresp,
    input logic          psel,
    input logic          penable,
    input logic          pwrite,
    input logic [AW-1:0] paddr,
    input logic [DW-1:0] pwdata,
    input logic          pready
);

    // R3
    apb_pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pen |=> $stable({psel, penable, pwrite, paddr, pwdata}));

    // R4
    setup_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !penable && pen) |=> (psel && penable));

    // R4
    access_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (penable && !(pen && pready)) |=> (psel && penable));

    // R5
    read_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite) |-> !buf_valid);

    // R7
    err_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hresp && !hreadyout) |=> (hresp && hreadyout));

    // R8
    wbuf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_valid && !(pen && penable && pwrite && pready)) |=> buf_valid);

endmodule

bind posted_apb_bridge pab_checker #(
    .AW (ADDR_W),
    .DW (DATA_W)
) u_pab_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pen       (pen),
    .buf_valid (buf_valid),
    .hreadyout (hreadyout),
    .hresp     (hresp),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .pwdata    (pwdata),
    .pready    (pready)
);

// File: tb/test_posted_apb_bridge.sv
// Bench for posted_apb_bridge with a small APB register peripheral.
// Peripheral map: word 0 holds a write-one-to-clear flag in bit 0, words 1..3
// are plain registers, and any address with bits [11:8] nonzero answers with
// PSLVERR (writes there are dropped, reads return 0).
module test_posted_apb_bridge;

    localparam int AW = 12;
    localparam int DW = 32;

    typedef struct packed {
        logic [4:0]  ratio;
        logic [1:0]  waits;
        logic [1:0]  idx;
        logic [31:0] wdata;
        logic [31:0] expv;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [0:NV-1] = '{
        '{5'd1,  2'd0, 2'd1, 32'hA5A5_0001, 32'hA5A5_0001},
        '{5'd2,  2'd0, 2'd2, 32'h1234_5678, 32'h1234_5678},
        '{5'd3,  2'd1, 2'd3, 32'hCAFE_F00D, 32'hCAFE_F00D},
        '{5'd4,  2'd0, 2'd0, 32'h0000_0001, 32'h0000_0000},
        '{5'd7,  2'd2, 2'd0, 32'h0000_0000, 32'h0000_0001},
        '{5'd16, 2'd0, 2'd0, 32'hFFFF_FFFF, 32'h0000_0000},
        '{5'd5,  2'd3, 2'd1, 32'h5A5A_0F0F, 32'h5A5A_0F0F},
        '{5'd1,  2'd1, 2'd0, 32'h0000_0001, 32'h0000_0000}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    div_ratio = 5'd1;
    logic          hsel = 1'b0;
    logic [AW-1:0] haddr = '0;
    logic [1:0]    htrans = 2'b00;
    logic          hwrite = 1'b0;
    logic [DW-1:0] hwdata = '0;
    logic          hready;
    logic          hreadyout;
    logic          hresp;
    logic [DW-1:0] hrdata;
    logic          pclk_en;
    logic          psel;
    logic          penable;
    logic          pwrite;
    logic [AW-1:0] paddr;
    logic [DW-1:0] pwdata;
    logic [DW-1:0] prdata;
    logic          pready;
    logic          pslverr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;
    assign hready = hreadyout;

    posted_apb_bridge #(
        .ADDR_W  (AW),
        .DATA_W  (DW),
        .MAX_DIV (16)
    ) i_posted_apb_bridge (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_ratio (div_ratio),
        .hsel      (hsel),
        .haddr     (haddr),
        .htrans    (htrans),
        .hwrite    (hwrite),
        .hwdata    (hwdata),
        .hready    (hready),
        .hreadyout (hreadyout),
        .hresp     (hresp),
        .hrdata    (hrdata),
        .pclk_en   (pclk_en),
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .pwdata    (pwdata),
        .prdata    (prdata),
        .pready    (pready),
        .pslverr   (pslverr)
    );

    // ---------------- APB peripheral model ----------------
    logic        flag;
    logic        flag_set_req = 1'b0;
    logic [1:0]  pwait = 2'd0;
    logic [1:0]  wcnt;
    logic [31:0] r1, r2, r3;
    logic        perr;
    logic [1:0]  pidx;

    assign perr    = (paddr[11:8] != 4'd0);
    assign pidx    = paddr[3:2];
    assign pready  = psel && penable && (wcnt == pwait);
    assign pslverr = pready && perr;

    always_comb begin
        if (perr)           prdata = 32'd0;
        else if (pidx == 0) prdata = {31'd0, flag};
        else if (pidx == 1) prdata = r1;
        else if (pidx == 2) prdata = r2;
        else                prdata = r3;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            wcnt <= 2'd0;
            flag <= 1'b0;
            r1 <= 32'd0;
            r2 <= 32'd0;
            r3 <= 32'd0;
        end else begin
            if (flag_set_req) flag <= 1'b1;
            if (pclk_en && psel && penable) begin
                if (wcnt == pwait) begin
                    wcnt <= 2'd0;
                    if (pwrite && !perr) begin
                        case (pidx)
                            2'd0: if (pwdata[0]) flag <= 1'b0;
                            2'd1: r1 <= pwdata;
                            2'd2: r2 <= pwdata;
                            default: r3 <= pwdata;
                        endcase
                    end
                end else begin
                    wcnt <= wcnt + 2'd1;
                end
            end
        end
    end

    // ---------------- APB pin monitor ----------------
    int          cyc = 0;
    int          t_sel = 0;
    int          t_en = 0;
    int          setup_len = 0;
    int          acc_len = 0;
    int          psel_rises = 0;
    int          hresp_seen = 0;
    logic        psel_d = 1'b0;
    logic        pen_d = 1'b0;
    logic [AW-1:0] mon_waddr = '0;
    logic [DW-1:0] mon_wdata = '0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (psel && !psel_d) begin
            t_sel = cyc;
            psel_rises = psel_rises + 1;
        end
        if (penable && !pen_d) begin
            t_en = cyc;
            setup_len = cyc - t_sel;
            if (pwrite) begin
                mon_waddr = paddr;
                mon_wdata = pwdata;
            end
        end
        if (!penable && pen_d) acc_len = cyc - t_en;
        if (hresp) hresp_seen = hresp_seen + 1;
        psel_d = psel;
        pen_d  = penable;
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse_flag();
        @(negedge clk) flag_set_req = 1'b1;
        @(negedge clk) flag_set_req = 1'b0;
    endtask

    // Write then read of the same address in back-to-back address phases
    task automatic wr_then_rd(input logic [AW-1:0] a, input logic [DW-1:0] d,
                              output bit wr_zero, output bit flag_after,
                              output logic [DW-1:0] rdat, output bit resp,
                              output bit flag_ret);
        @(negedge clk);
        hsel = 1'b1; htrans = 2'b10; hwrite = 1'b1; haddr = a;
        @(negedge clk);
        wr_zero = hreadyout;
        hwdata = d; htrans = 2'b10; hwrite = 1'b0; haddr = a;
        @(negedge clk);
        htrans = 2'b00;
        flag_after = flag;
        while (!hreadyout) @(negedge clk);
        rdat = hrdata; resp = hresp; flag_ret = flag;
    endtask

    task automatic ahb_write(input logic [AW-1:0] a, input logic [DW-1:0] d, output int ws);
        @(negedge clk);
        hsel = 1'b1; htrans = 2'b10; hwrite = 1'b1; haddr = a;
        @(negedge clk);
        htrans = 2'b00; hwdata = d; ws = 0;
        while (!hreadyout) begin ws++; @(negedge clk); end
    endtask

    task automatic ahb_read(input logic [AW-1:0] a, output logic [DW-1:0] rdat,
                            output bit resp, output bit saw_first);
        @(negedge clk);
        hsel = 1'b1; htrans = 2'b10; hwrite = 1'b0; haddr = a;
        @(negedge clk);
        htrans = 2'b00; saw_first = 1'b0;
        while (!hreadyout) begin
            if (hresp) saw_first = 1'b1;
            @(negedge clk);
        end
        rdat = hrdata; resp = hresp;
    endtask

    function automatic int clampr(input int r);
        if (r == 0) return 1;
        if (r > 16) return 16;
        return r;
    endfunction

    // ---------------- main sequence ----------------
    initial begin
        bit wz, fa, rs, fr, sf;
        logic [DW-1:0] rd;
        int ws, rises0, hr0;

        repeat (3) @(negedge clk);
        // R1 during reset
        chk(hreadyout && !hresp && !psel && !penable, "R1 in reset",
            {28'd0, hreadyout, hresp, psel, penable}, 32'h8);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 after release
        chk(hreadyout && !hresp && !psel && !penable, "R1 after reset",
            {28'd0, hreadyout, hresp, psel, penable}, 32'h8);

        // Table walk: posted write followed at once by a read
        for (int i = 0; i < NV; i++) begin
            div_ratio = VECS[i].ratio;
            pwait = VECS[i].waits;
            pulse_flag();
            wr_then_rd(AW'({VECS[i].idx, 2'b00}), VECS[i].wdata, wz, fa, rd, rs, fr);
            chk(wz, "R2 zero-wait write", {31'd0, wz}, 32'd1);
            chk(rd == VECS[i].expv && !rs, "R5/R6 read-after-write data", rd, VECS[i].expv);
            chk(mon_waddr == AW'({VECS[i].idx, 2'b00}) && mon_wdata == VECS[i].wdata,
                "R4 APB write payload", mon_wdata, VECS[i].wdata);
            chk(setup_len == clampr(VECS[i].ratio), "R3 setup length",
                setup_len, clampr(VECS[i].ratio));
            chk(acc_len == (VECS[i].waits + 1) * clampr(VECS[i].ratio), "R4 access length",
                acc_len, (VECS[i].waits + 1) * clampr(VECS[i].ratio));
            if (VECS[i].idx == 2'd0 && VECS[i].expv == 32'd0) begin
                chk(fa, "R5 flag still set after AHB write end", {31'd0, fa}, 32'd1);
                chk(!fr, "R5 flag clear at read return", {31'd0, fr}, 32'd0);
            end
        end

        // R9: IDLE and BUSY transfers are ignored
        div_ratio = 5'd2; pwait = 2'd0;
        rises0 = psel_rises;
        @(negedge clk);
        hsel = 1'b1; hwrite = 1'b1; haddr = 12'h004; hwdata = 32'hDEAD_0000;
        for (int k = 0; k < 8; k++) begin
            htrans = (k < 4) ? 2'b00 : 2'b01;
            @(negedge clk);
            chk(hreadyout, "R9 ready on IDLE/BUSY", {31'd0, hreadyout}, 32'd1);
        end
        htrans = 2'b00;
        repeat (40) @(negedge clk);
        chk(psel_rises == rises0, "R9 no APB transfer", psel_rises, rises0);
        ahb_read(12'h004, rd, rs, sf);
        chk(rd == 32'h5A5A_0F0F, "R9 register unchanged", rd, 32'h5A5A_0F0F);

        // R3: ratio clamping
        div_ratio = 5'd0;
        ahb_read(12'h008, rd, rs, sf);
        chk(setup_len == 1 && rd == 32'h1234_5678, "R3 ratio 0 acts as 1", setup_len, 1);
        div_ratio = 5'd20;
        ahb_read(12'h008, rd, rs, sf);
        chk(setup_len == 16, "R3 ratio above 16 clamps", setup_len, 16);

        // R7: read error gives two-cycle response
        div_ratio = 5'd3;
        ahb_read(12'h100, rd, rs, sf);
        chk(sf, "R7 first error cycle", {31'd0, sf}, 32'd1);
        chk(rs, "R7 second error cycle", {31'd0, rs}, 32'd1);
        ahb_read(12'h00C, rd, rs, sf);
        chk(!rs && rd == 32'hCAFE_F00D, "R7 next read clean", rd, 32'hCAFE_F00D);

        // R10: write error dropped
        hr0 = hresp_seen;
        ahb_write(12'h104, 32'h0BAD_0BAD, ws);
        chk(ws == 0, "R10 zero-wait errored write", ws, 0);
        repeat (30) @(negedge clk);
        chk(hresp_seen == hr0, "R10 no AHB error", hresp_seen, hr0);

        // R8: second write stalls on full buffer
        div_ratio = 5'd4; pwait = 2'd1;
        @(negedge clk);
        hsel = 1'b1; htrans = 2'b10; hwrite = 1'b1; haddr = 12'h004;
        @(negedge clk);
        chk(hreadyout, "R8 first write zero-wait", {31'd0, hreadyout}, 32'd1);
        hwdata = 32'h1111_2222; haddr = 12'h008;
        @(negedge clk);
        htrans = 2'b00; hwdata = 32'h3333_4444; ws = 0;
        while (!hreadyout) begin ws++; @(negedge clk); end
        chk(ws > 0, "R8 second write stalled", ws, 1);
        ahb_read(12'h004, rd, rs, sf);
        chk(rd == 32'h1111_2222, "R8 first write landed", rd, 32'h1111_2222);
        ahb_read(12'h008, rd, rs, sf);
        chk(rd == 32'h3333_4444, "R8 second write landed", rd, 32'h3333_4444);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule